// File: doc/BRIEF.md
# JTAG Test Access Port with 10-bit Instruction Decode

This block is the test access port of a device whose instruction register is ten bits wide. A 16-state controller advances on the rising edge of the test clock under the mode-select line. The active instruction chooses which data register sits between the serial input and the serial output. The candidates are a one-bit bypass stage, a 32-bit device identifier, a 32-bit user-defined word, an 8-bit configuration register, and an external boundary-scan cell chain. The chain is not built here: it receives the serial input directly, returns its last cell on one input pin, and takes its select and capture/shift/update strobes from this block.

Four mode outputs (sample/preload, external test, output-disable and clamp) tell the pin logic which boundary-scan behaviour applies. They take effect only when the configuration register holds exactly 0x01. Until that pattern is written, the boundary-scan instructions still route the scan path but leave the pins in functional mode. Any opcode outside the defined set behaves as bypass. Serial output changes on the falling clock edge and is enabled only while a shift state is active.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the standard 16-state diagram on the rising TCK edge. Five consecutive TMS=1 clocks reach Test-Logic-Reset from any state. TRST_n low at a rising edge also forces that state. Leaving an Update state with TMS=0 enters Run-Test/Idle.
- R2: In Test-Logic-Reset the active instruction becomes IDCODE (0x006). With IDCODE active, Capture-DR loads the ID_VALUE parameter, and the bits leave on TDO least significant bit first.
- R3: Capture-IR loads 10'b0000000001, which shifts out LSB first. The active instruction changes only at Update-IR or in Test-Logic-Reset.
- R4: USERCODE (0x007) selects a 32-bit register that captures the USER_VALUE parameter and shifts it out LSB first.
- R5: BYPASS (0x3FF) and every undefined opcode select a one-bit register. It captures 0, so TDO repeats TDI one shift later.
- R6: Opcode 0x013 selects an 8-bit configuration register. Capture-DR loads its current value, and Update-DR writes the shifted value into it. Reset and Test-Logic-Reset clear it to 0.
- R7: The boundary-scan modes are enabled only while the configuration register equals exactly 8'h01. Any other value, including 8'h03, keeps all four mode outputs low.
- R8: SAMPLE/PRELOAD (0x005), EXTEST (0x00F), and the two AC-coupled extest variants (0x08F, 0x04F) route the scan path through the external chain. TDO then follows chain_ret_i, and chain_sel_o is high. The chain strobes are high in Capture-DR, Shift-DR and Update-DR while the chain is selected.
- R9: mode_sample_o is high for 0x005. mode_extest_o is high for 0x00F, 0x08F and 0x04F. mode_highz_o is high for 0x00B, and mode_clamp_o for 0x00A. Each requires R7's enable, and at most one of the four is high at a time.
- R10: HIGHZ (0x00B) and CLAMP (0x00A) use the one-bit bypass register as their scan path, and that register captures 0.
- R11: TDO and tdo_en update on the falling TCK edge. tdo_en is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in (also feeds the boundary chain) |
| tdo | output | 1 | Serial data out, falling-edge registered |
| tdo_en | output | 1 | Output enable for tdo |
| chain_ret_i | input | 1 | Last cell of the external boundary-scan chain |
| chain_sel_o | output | 1 | Boundary chain is the selected data register |
| chain_capture_o | output | 1 | Chain capture strobe |
| chain_shift_o | output | 1 | Chain shift strobe |
| chain_update_o | output | 1 | Chain update strobe |
| mode_sample_o | output | 1 | Sample/preload mode active |
| mode_extest_o | output | 1 | External test mode active |
| mode_highz_o | output | 1 | All user outputs disabled |
| mode_clamp_o | output | 1 | Pins driven from update-register values |

## Verification
The bench builds the block with ID_VALUE = 32'h2345_60DD and USER_VALUE = 32'hC0DE_5A17. These values differ from the defaults and from each other, and both have mixed bit patterns, so a swapped register, a reversed shift order or a stuck bit shows up in a full 32-bit readback. The chain return pin is tied to the inverse of TDI, so a chain-routed scan can be told apart from the bypass path. This makes the boundary-scan routing, the exact-pattern gating of the configuration register (0x01 against 0x03), and the undefined-opcode fallback all observable at the ports.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W  = 10;
    localparam int ID_W  = 32;
    localparam int CFG_W = 8;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_CFG      = 10'h013;
    localparam opcode_t OP_SAMPLE   = 10'h005;
    localparam opcode_t OP_EXTEST   = 10'h00F;
    localparam opcode_t OP_XT_PULSE = 10'h08F;
    localparam opcode_t OP_XT_TRAIN = 10'h04F;
    localparam opcode_t OP_BYPASS   = 10'h3FF;
    localparam opcode_t OP_USERCODE = 10'h007;
    localparam opcode_t OP_IDCODE   = 10'h006;
    localparam opcode_t OP_HIGHZ    = 10'h00B;
    localparam opcode_t OP_CLAMP    = 10'h00A;

    // Fixed pattern captured into the instruction shift stage
    localparam opcode_t IR_CAPTURE  = opcode_t'(1);
    // Configuration value that enables boundary-scan modes
    localparam logic [CFG_W-1:0] CFG_ENABLE = CFG_W'(1);

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYPASS, DR_IDCODE, DR_USER, DR_CFG, DR_CHAIN
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e dr;
        logic    sample;
        logic    extest;
        logic    highz;
        logic    clamp;
    } decode_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic decode_t decode_op(opcode_t op);
        decode_t d;
        d.dr     = DR_BYPASS;
        d.sample = 1'b0;
        d.extest = 1'b0;
        d.highz  = 1'b0;
        d.clamp  = 1'b0;
        case (op)
            OP_IDCODE:   d.dr = DR_IDCODE;
            OP_USERCODE: d.dr = DR_USER;
            OP_CFG:      d.dr = DR_CFG;
            OP_SAMPLE: begin
                d.dr     = DR_CHAIN;
                d.sample = 1'b1;
            end
            OP_EXTEST, OP_XT_PULSE, OP_XT_TRAIN: begin
                d.dr     = DR_CHAIN;
                d.extest = 1'b1;
            end
            OP_HIGHZ:    d.highz = 1'b1;
            OP_CLAMP:    d.clamp = 1'b1;
            OP_BYPASS:   d.dr = DR_BYPASS;
            default:     d.dr = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    output opcode_t    ir,
    output logic       shift_lsb
);

    opcode_t sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            sh <= IR_CAPTURE;
            ir <= OP_IDCODE;
        end else begin
            case (state)
                ST_CAP_IR: sh <= IR_CAPTURE;
                ST_SHF_IR: sh <= {tdi, sh[IR_W-1:1]};
                ST_UPD_IR: ir <= sh;
                ST_RESET:  ir <= OP_IDCODE;
                default:   sh <= sh;
            endcase
        end
    end

    assign shift_lsb = sh[0];

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE   = 32'h1234_5679,
    parameter logic [ID_W-1:0] USER_VALUE = 32'hFFFF_FFFF
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  tap_state_e       state,
    input  dr_sel_e          sel,
    input  logic             chain_ret,
    output logic             dr_lsb,
    output logic [CFG_W-1:0] cfg
);

    logic [ID_W-1:0]  word_sh;
    logic [CFG_W-1:0] cfg_sh;
    logic             byp;
    logic             cap, shf, upd;

    assign cap = (state == ST_CAP_DR);
    assign shf = (state == ST_SHF_DR);
    assign upd = (state == ST_UPD_DR);

    // One shifter serves both 32-bit identity words
    always_ff @(posedge tck) begin
        if (rst) begin
            word_sh <= '0;
        end else if (sel == DR_IDCODE || sel == DR_USER) begin
            if (cap) begin
                word_sh <= (sel == DR_IDCODE) ? ID_VALUE : USER_VALUE;
            end else if (shf) begin
                word_sh <= {tdi, word_sh[ID_W-1:1]};
            end
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            cfg_sh <= '0;
            cfg    <= '0;
        end else if (state == ST_RESET) begin
            cfg    <= '0;
        end else if (sel == DR_CFG) begin
            if (cap) begin
                cfg_sh <= cfg;
            end else if (shf) begin
                cfg_sh <= {tdi, cfg_sh[CFG_W-1:1]};
            end else if (upd) begin
                cfg    <= cfg_sh;
            end
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp <= 1'b0;
        end else if (sel == DR_BYPASS) begin
            if (cap) begin
                byp <= 1'b0;
            end else if (shf) begin
                byp <= tdi;
            end
        end
    end

    always_comb begin
        case (sel)
            DR_IDCODE, DR_USER: dr_lsb = word_sh[0];
            DR_CFG:             dr_lsb = cfg_sh[0];
            DR_CHAIN:           dr_lsb = chain_ret;
            default:            dr_lsb = byp;
        endcase
    end

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE   = 32'h1234_5679,
    parameter logic [ID_W-1:0] USER_VALUE = 32'hFFFF_FFFF
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic chain_ret_i,
    output logic chain_sel_o,
    output logic chain_capture_o,
    output logic chain_shift_o,
    output logic chain_update_o,
    output logic mode_sample_o,
    output logic mode_extest_o,
    output logic mode_highz_o,
    output logic mode_clamp_o
);

    logic             rst;
    tap_state_e       st;
    opcode_t          ir_q;
    logic             ir_lsb;
    logic             dr_lsb;
    logic [CFG_W-1:0] cfg_q;
    decode_t          dec;
    logic             bscan_en;
    logic             shifting;

    assign rst = ~trst_n;

    jtag_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (st)
    );

    jtag_tap_ir u_ir (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (st),
        .ir        (ir_q),
        .shift_lsb (ir_lsb)
    );

    assign dec = decode_op(ir_q);

    jtag_tap_dr #(
        .ID_VALUE   (ID_VALUE),
        .USER_VALUE (USER_VALUE)
    ) u_dr (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (st),
        .sel       (dec.dr),
        .chain_ret (chain_ret_i),
        .dr_lsb    (dr_lsb),
        .cfg       (cfg_q)
    );

    assign bscan_en = (cfg_q == CFG_ENABLE);

    assign mode_sample_o = bscan_en & dec.sample;
    assign mode_extest_o = bscan_en & dec.extest;
    assign mode_highz_o  = bscan_en & dec.highz;
    assign mode_clamp_o  = bscan_en & dec.clamp;

    assign chain_sel_o     = (dec.dr == DR_CHAIN);
    assign chain_capture_o = chain_sel_o & (st == ST_CAP_DR);
    assign chain_shift_o   = chain_sel_o & (st == ST_SHF_DR);
    assign chain_update_o  = chain_sel_o & (st == ST_UPD_DR);

    assign shifting = (st == ST_SHF_IR) || (st == ST_SHF_DR);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            tdo    <= (st == ST_SHF_IR) ? ir_lsb : dr_lsb;
        end
    end

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
(
    input logic             tck,
    input logic             rst,
    input logic             tms,
    input tap_state_e       st,
    input opcode_t          ir,
    input logic [CFG_W-1:0] cfg,
    input logic             tdo_en,
    input logic             chain_sel,
    input logic             m_sample,
    input logic             m_extest,
    input logic             m_highz,
    input logic             m_clamp
);

    // R1
    upd_to_idle_chk: assert property (@(posedge tck) disable iff (rst)
        ((st == ST_UPD_DR || st == ST_UPD_IR) && !tms) |=> (st == ST_IDLE));

    // R2
    reset_ir_chk: assert property (@(posedge tck) disable iff (rst)
        (st == ST_RESET) |=> (ir == OP_IDCODE));

    // R3
    ir_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (st != ST_UPD_IR && st != ST_RESET) |=> $stable(ir));

    // R7
    mode_gate_chk: assert property (@(posedge tck) disable iff (rst)
        (m_sample || m_extest || m_highz || m_clamp) |-> (cfg == CFG_ENABLE));

    // R8
    chain_route_chk: assert property (@(posedge tck) disable iff (rst)
        (m_sample || m_extest) |-> chain_sel);

    // R9
    mode_onehot_chk: assert property (@(posedge tck) disable iff (rst)
        $onehot0({m_sample, m_extest, m_highz, m_clamp}));

    // R11
    tdo_en_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_en == (st == ST_SHF_DR || st == ST_SHF_IR));

endmodule

bind jtag_tap jtag_tap_chk u_chk (
    .tck       (tck),
    .rst       (rst),
    .tms       (tms),
    .st        (st),
    .ir        (ir_q),
    .cfg       (cfg_q),
    .tdo_en    (tdo_en),
    .chain_sel (chain_sel_o),
    .m_sample  (mode_sample_o),
    .m_extest  (mode_extest_o),
    .m_highz   (mode_highz_o),
    .m_clamp   (mode_clamp_o)
);

// File: tb/jtag_tap_tb.sv
module jtag_tap_tb;

    localparam logic [31:0] ID_V   = 32'h2345_60DD;
    localparam logic [31:0] USER_V = 32'hC0DE_5A17;
    localparam int WD_CYCLES = 150000;

    // bench-side state numbering
    localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7, UDR = 8;
    localparam int SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;
    localparam int P_BYP = 0, P_ID = 1, P_USER = 2, P_CFG = 3, P_CHAIN = 4;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en, chain_ret;
    logic chain_sel, chain_cap, chain_shf, chain_upd;
    logic m_sample, m_extest, m_highz, m_clamp;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit started = 0;

    assign chain_ret = ~tdi;

    always #5 tck = ~tck;

    jtag_tap #(.ID_VALUE(ID_V), .USER_VALUE(USER_V)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .chain_ret_i(chain_ret),
        .chain_sel_o(chain_sel), .chain_capture_o(chain_cap),
        .chain_shift_o(chain_shf), .chain_update_o(chain_upd),
        .mode_sample_o(m_sample), .mode_extest_o(m_extest),
        .mode_highz_o(m_highz), .mode_clamp_o(m_clamp)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int       ms = TLR;
    bit       q[$];
    bit [9:0] m_ir = 10'h006;
    bit [7:0] m_cfg = 8'h00;

    function automatic int path_of(bit [9:0] op);
        case (op)
            10'h006: return P_ID;
            10'h007: return P_USER;
            10'h013: return P_CFG;
            10'h005, 10'h00F, 10'h08F, 10'h04F: return P_CHAIN;
            default: return P_BYP;
        endcase
    endfunction

    function automatic int nxt(int s, bit m);
        case (s)
            TLR:  return m ? TLR : RTI;
            RTI:  return m ? SDR : RTI;
            SDR:  return m ? SIR : CDR;
            CDR, SHDR: return m ? E1DR : SHDR;
            E1DR: return m ? UDR : PDR;
            PDR:  return m ? E2DR : PDR;
            E2DR: return m ? UDR : SHDR;
            SIR:  return m ? TLR : CIR;
            CIR, SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR : PIR;
            PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR : SHIR;
            default: return m ? SDR : RTI; // both update states
        endcase
    endfunction

    always @(posedge tck) begin
        started = 1;
        if (!trst_n) begin
            ms = TLR; m_ir = 10'h006; m_cfg = 8'h00;
        end else begin
            int p;
            p = path_of(m_ir);
            case (ms)
                TLR: begin m_ir = 10'h006; m_cfg = 8'h00; end
                CIR: begin q.delete(); q.push_back(1'b1); for (int i = 1; i < 10; i++) q.push_back(1'b0); end
                SHIR: begin void'(q.pop_front()); q.push_back(tdi); end
                UIR: for (int i = 0; i < 10; i++) m_ir[i] = q[i];
                CDR: begin
                    q.delete();
                    if (p == P_ID)        for (int i = 0; i < 32; i++) q.push_back(ID_V[i]);
                    else if (p == P_USER) for (int i = 0; i < 32; i++) q.push_back(USER_V[i]);
                    else if (p == P_CFG)  for (int i = 0; i < 8; i++)  q.push_back(m_cfg[i]);
                    else if (p == P_BYP)  q.push_back(1'b0);
                end
                SHDR: if (p != P_CHAIN) begin void'(q.pop_front()); q.push_back(tdi); end
                UDR: if (p == P_CFG) for (int i = 0; i < 8; i++) m_cfg[i] = q[i];
                default: ;
            endcase
            ms = nxt(ms, tms);
        end
    end

    // per-clock comparison, away from both edges
    always @(negedge tck) begin
        #2;
        if (started && !done) begin
            bit en_exp, bs_en;
            int p;
            string tg;
            p = path_of(m_ir);
            en_exp = trst_n && (ms == SHIR || ms == SHDR);
            // R11
            chk(tdo_en === en_exp, "R11", {31'b0, tdo_en}, {31'b0, en_exp});
            if (en_exp) begin
                bit t_exp;
                if (ms == SHIR) begin t_exp = q[0]; tg = "R3"; end
                else if (p == P_CHAIN) begin t_exp = ~tdi; tg = "R8"; end
                else begin
                    t_exp = q[0];
                    case (p)
                        P_ID: tg = "R2";
                        P_USER: tg = "R4";
                        P_CFG: tg = "R6";
                        default: tg = (m_ir == 10'h00B || m_ir == 10'h00A) ? "R10" : "R5";
                    endcase
                end
                chk(tdo === t_exp, tg, {31'b0, tdo}, {31'b0, t_exp});
            end
            bs_en = (m_cfg == 8'h01);
            tg = bs_en ? "R9" : "R7";
            chk({m_sample, m_extest, m_highz, m_clamp} ===
                {bs_en && m_ir == 10'h005,
                 bs_en && (m_ir == 10'h00F || m_ir == 10'h08F || m_ir == 10'h04F),
                 bs_en && m_ir == 10'h00B, bs_en && m_ir == 10'h00A}, tg,
                {28'b0, m_sample, m_extest, m_highz, m_clamp}, 32'(m_ir));
            // R8 strobes
            chk({chain_sel, chain_cap, chain_shf, chain_upd} ===
                {p == P_CHAIN, p == P_CHAIN && ms == CDR, p == P_CHAIN && ms == SHDR, p == P_CHAIN && ms == UDR},
                "R8", {28'b0, chain_sel, chain_cap, chain_shf, chain_upd}, 32'(ms));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit tms_v, input bit tdi_v, output logic seen);
        @(posedge tck);
        #1;
        tms = tms_v;
        tdi = tdi_v;
        @(negedge tck);
        #3;
        seen = tdo;
    endtask

    task automatic scan(input bit ir_path, input int n, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        step(1'b1, 1'b0, o);
        if (ir_path) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic load_ir(input logic [9:0] op, input string tag);
        logic [31:0] r;
        scan(1'b1, 10, {22'b0, op}, r);
        // R3: capture pattern appears on every instruction scan
        chk(r[9:0] == 10'h001, tag, r, 32'h001);
    endtask

    initial begin
        logic [31:0] r;
        logic o;
        repeat (3) @(posedge tck);
        #1 trst_n = 1'b1; tms = 1'b0;
        @(negedge tck); #3;
        // R1 reset state
        chk(tdo_en == 1'b0, "R1", {31'b0, tdo_en}, 0);
        chk({m_sample, m_extest, m_highz, m_clamp, chain_sel} == 5'b0, "R1",
            {27'b0, m_sample, m_extest, m_highz, m_clamp, chain_sel}, 0);

        // R2 identity after reset
        scan(1'b0, 32, 32'hA5A5_0F0F, r);
        chk(r == ID_V, "R2", r, ID_V);

        // R4 user word
        load_ir(10'h007, "R3");
        scan(1'b0, 32, 32'h0000_0000, r);
        chk(r == USER_V, "R4", r, USER_V);

        // R5 bypass
        load_ir(10'h3FF, "R3");
        scan(1'b0, 8, 32'h0000_00B2, r);
        chk(r[7:0] == 8'h64, "R5", r, 32'h64);
        load_ir(10'h155, "R3");
        scan(1'b0, 4, 32'h0000_000F, r);
        chk(r[3:0] == 4'hE, "R5", r, 32'hE);

        // R7 / R10 highz without enable
        load_ir(10'h00B, "R3");
        chk(m_highz == 1'b0, "R7", {31'b0, m_highz}, 0);
        scan(1'b0, 3, 32'h0000_0007, r);
        chk(r[2:0] == 3'b110, "R10", r, 32'h6);

        // R6 configuration write and readback
        load_ir(10'h013, "R3");
        scan(1'b0, 8, 32'h0000_0001, r);
        chk(r[7:0] == 8'h00, "R6", r, 0);
        scan(1'b0, 8, 32'h0000_0001, r);
        chk(r[7:0] == 8'h01, "R6", r, 1);

        // R9 modes with enable
        load_ir(10'h00B, "R3");
        chk(m_highz == 1'b1, "R9", {31'b0, m_highz}, 1);
        load_ir(10'h00A, "R3");
        chk(m_clamp == 1'b1, "R9", {31'b0, m_clamp}, 1);
        scan(1'b0, 2, 32'h0000_0001, r);
        chk(r[1:0] == 2'b10, "R10", r, 2);
        load_ir(10'h005, "R3");
        chk(m_sample && chain_sel, "R9", {30'b0, m_sample, chain_sel}, 3);
        scan(1'b0, 6, 32'h0000_002D, r);
        chk(r[5:0] == 6'h12, "R8", r, 32'h12);
        load_ir(10'h08F, "R3");
        chk(m_extest == 1'b1, "R9", {31'b0, m_extest}, 1);
        load_ir(10'h04F, "R3");
        chk(m_extest == 1'b1, "R9", {31'b0, m_extest}, 1);
        load_ir(10'h00F, "R3");
        chk(m_extest == 1'b1, "R9", {31'b0, m_extest}, 1);

        // R7 non-exact pattern disables
        load_ir(10'h013, "R3");
        scan(1'b0, 8, 32'h0000_0003, r);
        load_ir(10'h00F, "R3");
        chk(m_extest == 1'b0 && chain_sel, "R7", {30'b0, m_extest, chain_sel}, 1);

        // R1 five TMS ones reach reset; IR back to IDCODE, cfg cleared
        load_ir(10'h013, "R3");
        scan(1'b0, 8, 32'h0000_0001, r);
        load_ir(10'h00F, "R3");
        chk(m_extest == 1'b1, "R9", {31'b0, m_extest}, 1);
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o); // into Shift-DR
        repeat (5) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        chk(m_extest == 1'b0 && !chain_sel, "R1", {30'b0, m_extest, chain_sel}, 0);
        scan(1'b0, 32, 32'h0, r);
        chk(r == ID_V, "R1", r, ID_V);

        // R1 trst mid instruction scan
        load_ir(10'h007, "R3");
        step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b1, o);
        @(posedge tck); #1 trst_n = 1'b0;
        @(posedge tck); #1 trst_n = 1'b1; tms = 1'b0;
        scan(1'b0, 32, 32'hFFFF_FFFF, r);
        chk(r == ID_V, "R1", r, ID_V);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 10);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule